// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a small load/store processor that takes several clock cycles per instruction. It holds one state register with fixed 4-bit codes. In each state it drives the datapath's register enables, memory strobes, multiplexer selects and ALU operation. The datapath, register file and memories sit outside the block. The sequencer sees only the opcode and function fields of the instruction register, the equality compare of the two register operands, and the ALU overflow flag.

Five instruction classes are sequenced: register-register arithmetic, OR with a zero-extended immediate, word load, word store and branch-on-equal. The block also traps two conditions. An opcode that matches no class is caught in decode. A signed add or subtract that overflows is caught in its execute state, and its result is never written back. A trap spends one cycle writing the exception PC register (the datapath forms PC minus 4) and the cause register, and loads the PC from a vector address that is a build parameter.

Top module: `mcyc_ctrl`

## Requirements
- R1: Synchronous active-high `rst` forces state 0000 (fetch), including in the middle of an instruction. Fetch asserts `ir_we`, `mem_rd` and `pc_we` with `pc_src`=0 (incremented PC), and always moves to state 0001 (decode).
- R2: Decode asserts `s_we` with `alu_a_sel`=0 (PC), `alu_b_sel`=3 (sign-extended offset shifted left by 2) and `alu_op`=0 (add), so S holds the branch target. The next state comes from the opcode: 000000 register-register, 001101 OR-immediate, 100011 load, 101011 store, 000100 branch.
- R3: Branch execute (0010) drives `alu_a_sel`=1 (A), `alu_b_sel`=0 (B) and `alu_op`=1 (subtract). It asserts `pc_we` with `pc_src`=1 (S) only when `a_eq_b` is high, and writes nothing else.
- R4: Register-register execute (0100) asserts `s_we` with A, B and `alu_op`=3 (function field). Its write-back state (0101) asserts `reg_we` with `reg_dst`=1 (rd) and `reg_src`=0 (S).
- R5: OR-immediate execute (0110) asserts `s_we` with A, `alu_b_sel`=2 (zero-extended immediate) and `alu_op`=2 (OR). The next state (0111) writes S to rt (`reg_dst`=0, `reg_src`=0). Overflow has no effect on this path.
- R6: A load visits 1000 (S = A + sign-extended offset: `alu_b_sel`=1, add), then 1001 (`mem_rd` and `m_we`), then 1010 (`reg_we`, rt, `reg_src`=1 for M).
- R7: A store visits 1000's twin 1011 (address, same ALU setting as the load) and then 1100 (`mem_wr`). It never writes the register file.
- R8: Any other opcode leaves decode for state 1101. That state asserts `epc_we`, `cause_we` with `cause_code`=10, and `pc_we` with `pc_src`=2 (vector).
- R9: In state 0100, overflow with function 100000 (add) or 100010 (subtract) leads to state 1110. That state does the same writes as R8 but with `cause_code`=12, and no register write follows. Overflow with any other function code proceeds to 0101 as normal.
- R10: `vec_addr` equals the EXC_VEC parameter. Every final state (0010, 0101, 0111, 1010, 1100, 1101, 1110) returns to 0000 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function field of the instruction register |
| a_eq_b | input | 1 | Operand A equals operand B |
| alu_ovf | input | 1 | Signed overflow from the ALU |
| state | output | 4 | Current state code |
| ir_we | output | 1 | Load instruction register from memory |
| pc_we | output | 1 | Load PC |
| pc_src | output | 2 | PC source: 0 increment, 1 S, 2 vector |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe (data B, address S) |
| s_we | output | 1 | Load ALU result register S |
| m_we | output | 1 | Load memory data register M |
| reg_we | output | 1 | Register file write |
| reg_dst | output | 1 | Write address: 0 rt, 1 rd |
| reg_src | output | 1 | Write data: 0 S, 1 M |
| alu_a_sel | output | 1 | ALU A: 0 PC, 1 A |
| alu_b_sel | output | 2 | ALU B: 0 B, 1 sign-ext, 2 zero-ext, 3 sign-ext shifted by 2 |
| alu_op | output | 2 | 0 add, 1 subtract, 2 OR, 3 function field |
| epc_we | output | 1 | Load exception PC with PC minus 4 |
| cause_we | output | 1 | Load cause register |
| cause_code | output | CAUSE_W | Cause value to load |
| vec_addr | output | ADDR_W | Exception vector address |

## Verification
The bench builds the block with ADDR_W=32, CAUSE_W=5 and EXC_VEC set to 32'h0000_0C40. This vector differs from the default, so a vector port still tied to the default value would be caught. A 5-bit cause port holds both codes 10 and 12 with a zero top bit, and a wrong zero-extension shows up in that bit. With these values the bench walks each class's full state trail back to back, both outcomes of the branch compare, and overflow under a trapping and a non-trapping function. It also walks overflow on the OR-immediate path, an undefined opcode, and a reset in the middle of a load.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int OPC_W   = 6;
    localparam int FN_W    = 6;
    localparam int STATE_W = 4;
    localparam int CODE_W  = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH    = 4'h0,
        ST_DECODE   = 4'h1,
        ST_BR_EXEC  = 4'h2,
        ST_RT_EXEC  = 4'h4,
        ST_RT_WB    = 4'h5,
        ST_ORI_EXEC = 4'h6,
        ST_ORI_WB   = 4'h7,
        ST_LW_ADDR  = 4'h8,
        ST_LW_MEM   = 4'h9,
        ST_LW_WB    = 4'hA,
        ST_SW_ADDR  = 4'hB,
        ST_SW_MEM   = 4'hC,
        ST_TRAP_ILL = 4'hD,
        ST_TRAP_OVF = 4'hE
    } mcc_state_e;

    typedef enum logic [2:0] {
        CL_RT, CL_ORI, CL_LW, CL_SW, CL_BEQ, CL_ILL
    } mcc_class_e;

    typedef enum logic [1:0] {
        PCS_INC = 2'd0, PCS_S = 2'd1, PCS_VEC = 2'd2
    } pc_src_e;

    typedef enum logic {
        ALUA_PC = 1'b0, ALUA_A = 1'b1
    } alu_a_e;

    typedef enum logic [1:0] {
        ALUB_B = 2'd0, ALUB_SX = 2'd1, ALUB_ZX = 2'd2, ALUB_SXS = 2'd3
    } alu_b_e;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_OR = 2'd2, ALU_FN = 2'd3
    } alu_op_e;

    localparam logic [OPC_W-1:0] OPC_RT  = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_ORI = 6'b001101;
    localparam logic [OPC_W-1:0] OPC_LW  = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_SW  = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BEQ = 6'b000100;

    localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FN_W-1:0] FN_SUB = 6'b100010;

    localparam logic [CODE_W-1:0] CAUSE_ILL = 4'd10;
    localparam logic [CODE_W-1:0] CAUSE_OVF = 4'd12;

    typedef struct packed {
        logic                ir_we;
        logic                pc_we;
        pc_src_e             pc_src;
        logic                mem_rd;
        logic                mem_wr;
        logic                s_we;
        logic                m_we;
        logic                reg_we;
        logic                reg_dst_rd;
        logic                reg_src_m;
        alu_a_e              alu_a;
        alu_b_e              alu_b;
        alu_op_e             alu_op;
        logic                epc_we;
        logic                cause_we;
        logic [CODE_W-1:0]   cause;
    } mcc_ctrl_t;

    function automatic logic is_final(mcc_state_e s);
        return (s == ST_BR_EXEC) || (s == ST_RT_WB) || (s == ST_ORI_WB) ||
               (s == ST_LW_WB) || (s == ST_SW_MEM) ||
               (s == ST_TRAP_ILL) || (s == ST_TRAP_OVF);
    endfunction

    function automatic logic fn_traps(logic [FN_W-1:0] fn);
        return (fn == FN_ADD) || (fn == FN_SUB);
    endfunction

endpackage

// File: rtl/mcc_opclass.sv
module mcc_opclass
    import mcc_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  funct,
    output mcc_class_e       op_class,
    output logic             trap_fn
);

    always_comb begin
        unique case (opcode)
            OPC_RT:  op_class = CL_RT;
            OPC_ORI: op_class = CL_ORI;
            OPC_LW:  op_class = CL_LW;
            OPC_SW:  op_class = CL_SW;
            OPC_BEQ: op_class = CL_BEQ;
            default: op_class = CL_ILL;
        endcase
    end

    assign trap_fn = fn_traps(funct);

endmodule

// File: rtl/mcc_seq.sv
module mcc_seq
    import mcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  mcc_class_e op_class,
    input  logic       trap_fn,
    input  logic       alu_ovf,
    output mcc_state_e state_q
);

    mcc_state_e state_d;

    always_comb begin
        state_d = ST_FETCH;
        case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: begin
                case (op_class)
                    CL_RT:   state_d = ST_RT_EXEC;
                    CL_ORI:  state_d = ST_ORI_EXEC;
                    CL_LW:   state_d = ST_LW_ADDR;
                    CL_SW:   state_d = ST_SW_ADDR;
                    CL_BEQ:  state_d = ST_BR_EXEC;
                    default: state_d = ST_TRAP_ILL;
                endcase
            end
            ST_RT_EXEC:  state_d = (trap_fn && alu_ovf) ? ST_TRAP_OVF : ST_RT_WB;
            ST_ORI_EXEC: state_d = ST_ORI_WB;
            ST_LW_ADDR:  state_d = ST_LW_MEM;
            ST_LW_MEM:   state_d = ST_LW_WB;
            ST_SW_ADDR:  state_d = ST_SW_MEM;
            default:     state_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH) |=> (state_q == ST_DECODE)); // R1

    AST_ILL_TRAPS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DECODE && op_class == CL_ILL) |=> (state_q == ST_TRAP_ILL)); // R8

    AST_OVF_TRAPS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RT_EXEC && trap_fn && alu_ovf) |=> (state_q == ST_TRAP_OVF)); // R9

    AST_FINAL_RETURNS: assert property (@(posedge clk) disable iff (rst)
        is_final(state_q) |=> (state_q == ST_FETCH)); // R10

endmodule

// File: rtl/mcc_ctrl_decode.sv
module mcc_ctrl_decode
    import mcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  mcc_state_e state_q,
    input  logic       a_eq_b,
    output mcc_ctrl_t  ctl
);

    always_comb begin
        ctl            = '0;
        ctl.pc_src     = PCS_INC;
        ctl.alu_a      = ALUA_PC;
        ctl.alu_b      = ALUB_B;
        ctl.alu_op     = ALU_ADD;
        case (state_q)
            ST_FETCH: begin
                ctl.ir_we  = 1'b1;
                ctl.mem_rd = 1'b1;
                ctl.pc_we  = 1'b1;
                ctl.pc_src = PCS_INC;
            end
            ST_DECODE: begin
                ctl.s_we  = 1'b1;
                ctl.alu_a = ALUA_PC;
                ctl.alu_b = ALUB_SXS;
            end
            ST_BR_EXEC: begin
                ctl.alu_a  = ALUA_A;
                ctl.alu_op = ALU_SUB;
                ctl.pc_we  = a_eq_b;
                ctl.pc_src = PCS_S;
            end
            ST_RT_EXEC: begin
                ctl.s_we   = 1'b1;
                ctl.alu_a  = ALUA_A;
                ctl.alu_op = ALU_FN;
            end
            ST_ORI_EXEC: begin
                ctl.s_we   = 1'b1;
                ctl.alu_a  = ALUA_A;
                ctl.alu_b  = ALUB_ZX;
                ctl.alu_op = ALU_OR;
            end
            ST_LW_ADDR, ST_SW_ADDR: begin
                ctl.s_we  = 1'b1;
                ctl.alu_a = ALUA_A;
                ctl.alu_b = ALUB_SX;
            end
            ST_LW_MEM: begin
                ctl.mem_rd = 1'b1;
                ctl.m_we   = 1'b1;
            end
            ST_RT_WB: begin
                ctl.reg_we     = 1'b1;
                ctl.reg_dst_rd = 1'b1;
            end
            ST_ORI_WB: ctl.reg_we = 1'b1;
            ST_LW_WB: begin
                ctl.reg_we    = 1'b1;
                ctl.reg_src_m = 1'b1;
            end
            ST_SW_MEM: ctl.mem_wr = 1'b1;
            ST_TRAP_ILL, ST_TRAP_OVF: begin
                ctl.epc_we   = 1'b1;
                ctl.cause_we = 1'b1;
                ctl.pc_we    = 1'b1;
                ctl.pc_src   = PCS_VEC;
                ctl.cause    = (state_q == ST_TRAP_ILL) ? CAUSE_ILL : CAUSE_OVF;
            end
            default: ;
        endcase
    end

    AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(ctl.mem_rd && ctl.mem_wr)); // R6

    AST_BRANCH_GATED: assert property (@(posedge clk) disable iff (rst)
        (ctl.pc_we && ctl.pc_src == PCS_S) |-> a_eq_b); // R3

    AST_TRAP_WRITES: assert property (@(posedge clk) disable iff (rst)
        ctl.epc_we |-> (ctl.cause_we && ctl.pc_we && ctl.pc_src == PCS_VEC && !ctl.reg_we)); // R8

endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
    import mcc_pkg::*;
#(
    parameter int                ADDR_W  = 32,
    parameter int                CAUSE_W = 5,
    parameter logic [ADDR_W-1:0] EXC_VEC = 32'h0000_0080
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [5:0]         opcode,
    input  logic [5:0]         funct,
    input  logic               a_eq_b,
    input  logic               alu_ovf,
    output logic [3:0]         state,
    output logic               ir_we,
    output logic               pc_we,
    output logic [1:0]         pc_src,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               s_we,
    output logic               m_we,
    output logic               reg_we,
    output logic               reg_dst,
    output logic               reg_src,
    output logic               alu_a_sel,
    output logic [1:0]         alu_b_sel,
    output logic [1:0]         alu_op,
    output logic               epc_we,
    output logic               cause_we,
    output logic [CAUSE_W-1:0] cause_code,
    output logic [ADDR_W-1:0]  vec_addr
);

    mcc_class_e op_class;
    logic       trap_fn;
    mcc_state_e state_q;
    mcc_ctrl_t  ctl;

    mcc_opclass u_opclass (
        .opcode   (opcode),
        .funct    (funct),
        .op_class (op_class),
        .trap_fn  (trap_fn)
    );

    mcc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .op_class (op_class),
        .trap_fn  (trap_fn),
        .alu_ovf  (alu_ovf),
        .state_q  (state_q)
    );

    mcc_ctrl_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .state_q (state_q),
        .a_eq_b  (a_eq_b),
        .ctl     (ctl)
    );

    assign state      = state_q;
    assign ir_we      = ctl.ir_we;
    assign pc_we      = ctl.pc_we;
    assign pc_src     = ctl.pc_src;
    assign mem_rd     = ctl.mem_rd;
    assign mem_wr     = ctl.mem_wr;
    assign s_we       = ctl.s_we;
    assign m_we       = ctl.m_we;
    assign reg_we     = ctl.reg_we;
    assign reg_dst    = ctl.reg_dst_rd;
    assign reg_src    = ctl.reg_src_m;
    assign alu_a_sel  = ctl.alu_a;
    assign alu_b_sel  = ctl.alu_b;
    assign alu_op     = ctl.alu_op;
    assign epc_we     = ctl.epc_we;
    assign cause_we   = ctl.cause_we;
    assign cause_code = CAUSE_W'(ctl.cause);
    assign vec_addr   = EXC_VEC;

    AST_OVF_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RT_EXEC && trap_fn && alu_ovf) |=> (!reg_we && epc_we)); // R9

    AST_ILL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (state == 4'hD) |-> (cause_we && cause_code == CAUSE_W'(10))); // R8

endmodule

// File: tb/test_mcyc_ctrl.sv
module test_mcyc_ctrl;

    localparam int          ADDR_W  = 32;
    localparam int          CAUSE_W = 5;
    localparam logic [31:0] VEC     = 32'h0000_0C40;
    localparam int          NV      = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [5:0] opcode = 6'h0;
    logic [5:0] funct = 6'h0;
    logic a_eq_b = 1'b0;
    logic alu_ovf = 1'b0;
    logic [3:0] state;
    logic ir_we, pc_we, mem_rd, mem_wr, s_we, m_we, reg_we, reg_dst, reg_src;
    logic alu_a_sel, epc_we, cause_we;
    logic [1:0] pc_src, alu_b_sel, alu_op;
    logic [CAUSE_W-1:0] cause_code;
    logic [ADDR_W-1:0] vec_addr;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mcyc_ctrl #(.ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W), .EXC_VEC(VEC)) i_mcyc_ctrl (
        .clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .a_eq_b(a_eq_b),
        .alu_ovf(alu_ovf), .state(state), .ir_we(ir_we), .pc_we(pc_we),
        .pc_src(pc_src), .mem_rd(mem_rd), .mem_wr(mem_wr), .s_we(s_we),
        .m_we(m_we), .reg_we(reg_we), .reg_dst(reg_dst), .reg_src(reg_src),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
        .epc_we(epc_we), .cause_we(cause_we), .cause_code(cause_code),
        .vec_addr(vec_addr)
    );

    // {opcode, funct, a_eq_b, alu_ovf, length, five state codes}
    localparam logic [36:0] VECS [NV] = '{
        {6'h00, 6'h20, 1'b0, 1'b0, 3'd4, 4'h0, 4'h1, 4'h4, 4'h5, 4'h0}, // R4 add
        {6'h00, 6'h22, 1'b0, 1'b1, 3'd4, 4'h0, 4'h1, 4'h4, 4'hE, 4'h0}, // R9 sub ovf
        {6'h00, 6'h21, 1'b0, 1'b1, 3'd4, 4'h0, 4'h1, 4'h4, 4'h5, 4'h0}, // R9 non-trapping
        {6'h0D, 6'h00, 1'b0, 1'b0, 3'd4, 4'h0, 4'h1, 4'h6, 4'h7, 4'h0}, // R5
        {6'h23, 6'h00, 1'b0, 1'b0, 3'd5, 4'h0, 4'h1, 4'h8, 4'h9, 4'hA}, // R6
        {6'h2B, 6'h00, 1'b0, 1'b0, 3'd4, 4'h0, 4'h1, 4'hB, 4'hC, 4'h0}, // R7
        {6'h04, 6'h00, 1'b1, 1'b0, 3'd3, 4'h0, 4'h1, 4'h2, 4'h0, 4'h0}, // R3 taken
        {6'h04, 6'h00, 1'b0, 1'b0, 3'd3, 4'h0, 4'h1, 4'h2, 4'h0, 4'h0}, // R3 not taken
        {6'h3F, 6'h00, 1'b0, 1'b0, 3'd3, 4'h0, 4'h1, 4'hD, 4'h0, 4'h0}, // R8
        {6'h0D, 6'h20, 1'b0, 1'b1, 3'd4, 4'h0, 4'h1, 4'h6, 4'h7, 4'h0}, // R5 ovf ignored
        {6'h00, 6'h20, 1'b0, 1'b1, 3'd4, 4'h0, 4'h1, 4'h4, 4'hE, 4'h0}  // R9 add ovf
    };

    function automatic string tag_of(logic [3:0] s);
        case (s)
            4'h0: return "R1";
            4'h1: return "R2";
            4'h2: return "R3";
            4'h4, 4'h5: return "R4";
            4'h6, 4'h7: return "R5";
            4'h8, 4'h9, 4'hA: return "R6";
            4'hB, 4'hC: return "R7";
            4'hD: return "R8";
            default: return "R9";
        endcase
    endfunction

    // {ir_we, pc_we, pc_src, mem_rd, mem_wr, s_we, m_we, reg_we, reg_dst, reg_src, epc_we, cause_we}
    function automatic logic [12:0] exp_sig(logic [3:0] s, logic eq);
        case (s)
            4'h0: return 13'b1_1_00_1_0_0_0_0_0_0_0_0;
            4'h1: return 13'b0_0_00_0_0_1_0_0_0_0_0_0;
            4'h2: return eq ? 13'b0_1_01_0_0_0_0_0_0_0_0_0 : 13'b0;
            4'h4, 4'h6, 4'h8, 4'hB: return 13'b0_0_00_0_0_1_0_0_0_0_0_0;
            4'h5: return 13'b0_0_00_0_0_0_0_1_1_0_0_0;
            4'h7: return 13'b0_0_00_0_0_0_0_1_0_0_0_0;
            4'h9: return 13'b0_0_00_1_0_0_1_0_0_0_0_0;
            4'hA: return 13'b0_0_00_0_0_0_0_1_0_1_0_0;
            4'hC: return 13'b0_0_00_0_1_0_0_0_0_0_0_0;
            4'hD, 4'hE: return 13'b0_1_10_0_0_0_0_0_0_0_1_1;
            default: return 13'b0;
        endcase
    endfunction

    // {valid, alu_a_sel, alu_b_sel, alu_op}
    function automatic logic [5:0] exp_alu(logic [3:0] s);
        case (s)
            4'h1: return 6'b1_0_11_00;
            4'h2: return 6'b1_1_00_01;
            4'h4: return 6'b1_1_00_11;
            4'h6: return 6'b1_1_10_10;
            4'h8, 4'hB: return 6'b1_1_01_00;
            default: return 6'b0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_state(input string tag, input logic [3:0] exp_s, input logic eq);
        logic [12:0] sig;
        logic [5:0]  al;
        chk(tag, "state", 32'(state), 32'(exp_s));
        sig = {ir_we, pc_we, (pc_we ? pc_src : 2'b00), mem_rd, mem_wr, s_we, m_we,
               reg_we, (reg_we ? reg_dst : 1'b0), (reg_we ? reg_src : 1'b0),
               epc_we, cause_we};
        chk(tag_of(exp_s), "controls", 32'(sig), 32'(exp_sig(exp_s, eq)));
        al = exp_alu(exp_s);
        if (al[5])
            chk(tag_of(exp_s), "alu", 32'({alu_a_sel, alu_b_sel, alu_op}), 32'(al[4:0]));
        if (exp_s == 4'hD) chk("R8", "cause", 32'(cause_code), 32'd10);
        if (exp_s == 4'hE) chk("R9", "cause", 32'(cause_code), 32'd12);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset state", 32'(state), 32'h0);
        chk("R10", "vector", 32'(vec_addr), VEC);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            logic [36:0] e;
            int len;
            e = VECS[v];
            opcode  = e[36:31];
            funct   = e[30:25];
            a_eq_b  = e[24];
            alu_ovf = e[23];
            len     = int'(e[22:20]);
            for (int k = 0; k < len; k++) begin
                logic [3:0] es;
                es = e[19 - 4*k -: 4];
                if (k > 0) @(negedge clk);
                chk_state((k == 0 && v > 0) ? "R10" : tag_of(es), es, a_eq_b);
            end
            @(negedge clk);
        end
        chk("R10", "return to fetch", 32'(state), 32'h0);

        // Reset in the middle of a load
        opcode = 6'h23; funct = 6'h00; a_eq_b = 1'b0; alu_ovf = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6", "load address state", 32'(state), 32'h8);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "mid-instruction reset", 32'(state), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "decode after reset", 32'(state), 32'h1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule